// File: doc/BRIEF.md
# MSI Doorbell Pending Injector

This block gives an interrupt controller a small memory-mapped doorbell window. A bus agent, typically a device that signals interrupts by sending a write to memory, writes an interrupt number to the doorbell register. The block then sets the matching bit in a pending bitmap made of 32-bit words. That bitmap feeds the controller's existing priority and CPU-delivery logic, which are outside this block.

The block decodes its own address window against a configured base. It stores the last doorbell value, which can be read back. It has a clear port that the acknowledge logic uses to retire pending bits. Every request that the window claims gets exactly one response cycle, and that response carries an error flag. A doorbell write also raises a one-cycle re-evaluation pulse, so the controller rescans its pending state.

Top module: `msi_doorbell`

## Requirements
- R1: After reset, the doorbell register reads as zero, every pending bit is clear, and `rsp_valid` and `eval_pulse` are low.
- R2: When `win_base` is zero, the window claims no address, so a request produces no response and changes no state.
- R3: A request is claimed when `win_base <= req_addr < win_base + WIN_SIZE`. A claimed request gets `rsp_valid` high for exactly the one cycle after the request cycle. An unclaimed request gives no response.
- R4: Only offset `DOOR_OFF` (address minus base, default 0) holds the doorbell register. A read or write at any other offset in the window responds with `rsp_err` = 1 and `rsp_rdata` = 0, and changes neither the register nor the bitmap.
- R5: A write at the doorbell offset latches all 32 data bits. A later read there returns that word in `rsp_rdata` with `rsp_err` = 0. A write response returns `rsp_rdata` = 0.
- R6: A doorbell write of ID < `NUM_LINES` sets bit ID%32 of pending word ID/32, which is flat bit `pend_words[ID]`. All other bits stay unchanged. The new bit is visible in the response cycle. ID is the data word read as a little-endian integer: byte lane 0 (bits 7:0) is least significant, and with the default `SWAP_BYTES` = 0 this means ID equals `req_wdata`.
- R7: A doorbell write of ID >= `NUM_LINES` leaves the bitmap unchanged and responds with `rsp_err` = 1. The register still latches the data.
- R8: Every write at the doorbell offset, in range or not, pulses `eval_pulse` high in its response cycle. No other access does this.
- R9: A `clr_valid` cycle clears `pend_words[clr_id]` from the next cycle onward. If a doorbell write sets the same bit in the same cycle, the set wins and the bit stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_base | input | AW | Window base address; zero disables the window |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a claimed request |
| rsp_err | output | 1 | Bad offset or out-of-range interrupt number |
| rsp_rdata | output | 32 | Read data |
| clr_valid | input | 1 | Pending-bit clear strobe from acknowledge logic |
| clr_id | input | IDW | Interrupt number to clear |
| eval_pulse | output | 1 | Request to re-evaluate interrupt state |
| pend_words | output | NWORDS*32 | Pending bitmap, word w in bits 32w+31:32w |

## Verification
All results of a request are due in the cycle after the request edge. These are the response strobe, error flag, read data, pending bit and re-evaluation pulse, because one register stage lies between the request and every output. A clear likewise shows one cycle later. The bench drives inputs on the falling edge. A behavioural model updates on each rising edge, and the comparison runs 1 ns after that edge against every output, so each result is checked in the exact cycle it is due. Directed checks for reset, the disabled window, out-of-range numbers and a set/clear collision sample at the same point.

// File: rtl/msi_doorbell.sv
module msi_doorbell #(
  parameter int AW         = 32,
  parameter int NUM_LINES  = 96,
  parameter int WIN_SIZE   = 16,
  parameter int DOOR_OFF   = 0,
  parameter bit SWAP_BYTES = 1'b0,
  localparam int NWORDS    = (NUM_LINES + 31) / 32,
  localparam int PW        = NWORDS * 32,
  localparam int IDW       = $clog2(PW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  win_base,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [31:0]    req_wdata,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [31:0]    rsp_rdata,
  input  logic           clr_valid,
  input  logic [IDW-1:0] clr_id,
  output logic           eval_pulse,
  output logic [PW-1:0]  pend_words
);

  logic [31:0]   door_q;
  logic [PW-1:0] pend_q;
  logic [31:0]   irq_num;
  logic [AW:0]   win_end;
  logic [AW-1:0] offset;
  logic          hit, at_door, door_wr, in_range;
  logic [PW-1:0] set_mask, clr_mask;

  generate
    if (SWAP_BYTES) begin : g_swap
      assign irq_num = {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]};
    end else begin : g_le
      assign irq_num = req_wdata;
    end
  endgenerate

  assign win_end  = {1'b0, win_base} + (AW+1)'(WIN_SIZE);
  assign hit      = req_valid && (|win_base) && (req_addr >= win_base)
                    && ({1'b0, req_addr} < win_end);
  assign offset   = req_addr - win_base;
  assign at_door  = hit && (offset == AW'(DOOR_OFF));
  assign door_wr  = at_door && req_write;
  assign in_range = irq_num < 32'(NUM_LINES);

  assign set_mask = (door_wr && in_range) ? (PW'(1) << irq_num[IDW-1:0]) : '0;
  assign clr_mask = clr_valid ? (PW'(1) << clr_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      door_q     <= '0;
      pend_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      eval_pulse <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~clr_mask) | set_mask;
      rsp_valid  <= hit;
      rsp_err    <= hit && (!at_door || (req_write && !in_range));
      rsp_rdata  <= (at_door && !req_write) ? door_q : '0;
      eval_pulse <= door_wr;
      if (door_wr) door_q <= req_wdata;
    end
  end

  assign pend_words = pend_q;

endmodule

// File: rtl/msi_doorbell_chk.sv
module msi_doorbell_chk #(
  parameter int AW = 32,
  parameter int PW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] win_base,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [31:0]   rsp_rdata,
  input logic          eval_pulse,
  input logic [PW-1:0] pend_words,
  input logic [31:0]   door_q
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> (pend_words == '0 && door_q == '0));

  a_r3_rsp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r2_base_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_base == '0) |=> !rsp_valid);

  a_r4_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  a_r5_door_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(door_q));

  a_r6_no_set_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ((pend_words & ~$past(pend_words)) == '0));

  a_r6_one_set_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_words & ~$past(pend_words)) <= 1);

  a_r8_eval_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    eval_pulse |-> rsp_valid);

endmodule

bind msi_doorbell msi_doorbell_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_base(win_base), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .eval_pulse(eval_pulse), .pend_words(pend_words), .door_q(door_q)
);

// File: tb/msi_doorbell_test.sv
`timescale 1ns/1ps
module msi_doorbell_test;
  localparam int AW = 32, NL = 96, WS = 16, PW = 96, IDW = 7;
  localparam logic [31:0] BASE = 32'h4000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] win_base = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic clr_valid = 1'b0;
  logic [IDW-1:0] clr_id = '0;
  logic rsp_valid, rsp_err, eval_pulse;
  logic [31:0] rsp_rdata;
  logic [PW-1:0] pend_words;

  always #2.5 clk = ~clk;

  msi_doorbell uut (
    .clk(clk), .rst_n(rst_n), .win_base(win_base), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .clr_valid(clr_valid), .clr_id(clr_id), .eval_pulse(eval_pulse),
    .pend_words(pend_words)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  logic e_valid = 0, e_err = 0, e_eval = 0;
  logic [31:0] e_rdata = 0, e_door = 0;
  logic [PW-1:0] e_pend = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_err = 0; e_eval = 0; e_rdata = 0; e_door = 0; e_pend = '0;
    end else begin
      longint a, b, off;
      bit hit;
      a = longint'(req_addr); b = longint'(win_base);
      hit = req_valid && b != 0 && a >= b && a < b + WS;
      off = a - b;
      if (clr_valid) e_pend[clr_id] = 1'b0;
      e_valid = hit; e_err = 0; e_eval = 0; e_rdata = 0;
      if (hit) begin
        if (off != 0) e_err = 1;
        else if (req_write) begin
          e_door = req_wdata;
          e_eval = 1;
          if (req_wdata < NL) e_pend[req_wdata] = 1'b1;
          else e_err = 1;
        end else e_rdata = e_door;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    cycles++;
    if (rst_n && !done) begin
      chk(rsp_valid == e_valid, "R3 rsp_valid", rsp_valid, e_valid);
      chk(rsp_err == e_err, "R4 rsp_err", rsp_err, e_err);
      chk(rsp_rdata == e_rdata, "R5 rsp_rdata", rsp_rdata, e_rdata);
      chk(eval_pulse == e_eval, "R8 eval_pulse", eval_pulse, e_eval);
      chk(pend_words == e_pend, "R6 pend_words", pend_words[63:0], e_pend[63:0]);
    end
  end

  task automatic req(input bit wr, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pend_words == '0, "R1 pend after reset", pend_words[63:0], 0);
    chk(!rsp_valid && !eval_pulse, "R1 outputs idle", {rsp_valid, eval_pulse}, 0);
    // R2 window disabled
    req(1, 32'h0000_0000, 32'd5);
    chk(!rsp_valid && pend_words == '0, "R2 base zero ignored", rsp_valid, 0);
    req(1, 32'h0000_0004, 32'd6);
    win_base = BASE;
    req(0, BASE, 0);
    chk(rsp_rdata == 0, "R1 doorbell reads zero", rsp_rdata, 0);
    // R5 / R6 main function
    req(1, BASE, 32'd37);
    req(0, BASE, 0);
    chk(rsp_rdata == 32'd37 && pend_words[37], "R5 readback and R6 bit 37", rsp_rdata, 37);
    req(1, BASE, 32'd0);
    req(1, BASE, 32'd31);
    req(1, BASE, 32'd32);
    req(1, BASE, 32'd95);
    chk(pend_words[95] && pend_words[32] && pend_words[31] && pend_words[0], "R6 word edges",
        pend_words[63:0], 64'h0000_0021_8000_0001);
    // R7 out of range
    req(1, BASE, 32'd96);
    chk(pend_words[95:0] == e_pend, "R7 range ignored", pend_words[63:0], e_pend[63:0]);
    req(1, BASE, 32'hDEAD_BEEF);
    req(0, BASE, 0);
    chk(rsp_rdata == 32'hDEAD_BEEF, "R7 register latched", rsp_rdata, 32'hDEAD_BEEF);
    // R4 bad offsets
    req(1, BASE + 4, 32'd3);
    chk(!pend_words[3] && rsp_err, "R4 bad offset write", pend_words[3], 0);
    req(0, BASE + 15, 0);
    req(0, BASE, 0);
    chk(rsp_rdata == 32'hDEAD_BEEF, "R4 register unchanged", rsp_rdata, 32'hDEAD_BEEF);
    // R3 window edges
    req(1, BASE + 16, 32'd4);
    req(1, BASE - 4, 32'd4);
    chk(!pend_words[4], "R3 outside window", pend_words[4], 0);
    // R9 clear and collision
    @(negedge clk); clr_valid = 1; clr_id = 7'd37;
    @(negedge clk); clr_valid = 0;
    chk(!pend_words[37], "R9 clear", pend_words[37], 0);
    @(negedge clk);
    clr_valid = 1; clr_id = 7'd50;
    req_valid = 1; req_write = 1; req_addr = BASE; req_wdata = 32'd50;
    @(negedge clk);
    clr_valid = 0; req_valid = 0; req_write = 0;
    chk(pend_words[50], "R9 set wins", pend_words[50], 1);
    // back-to-back
    for (int i = 60; i < 70; i++) req(1, BASE, i);
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule